// File: doc/BRIEF.md
# Branch Trace Buffer with Repeat Compression

This block keeps a history of taken branches for debug. Each qualifying branch event supplies a source and a destination program counter, and the pair is kept in a circular store of `2**DEPTH_LOG2` entries. Software reaches the block through a word-wide memory-mapped port. That port has three registers: a control register, a status register that reports how many pairs are held, and a data register. Each read of the data register takes one half of the newest pair. Loops that run the same branch over and over are folded into entries that already exist and do not fill the store. When the store is full, a control bit picks one of two outcomes: the oldest pair is overwritten, or the event is refused and an overflow-exception request is raised.

The bus port has two state machines. The response machine has states `RSP_IDLE`, `RSP_OK` and `RSP_ERR`. Every request moves it to `RSP_OK` if the access is well formed, or to `RSP_ERR` if it is not. Without a request it moves to `RSP_IDLE`. In `RSP_OK` or `RSP_ERR` the block drives `bus_ack` and the read data for exactly one cycle. The readout machine has states `PH_DST` and `PH_SRC`. A data read of a non-empty store moves it from `PH_DST` to `PH_SRC`, returning the destination half. The next data read moves it from `PH_SRC` back to `PH_DST`, returning the source half and removing the entry. A read of an empty store leaves the readout machine where it is.

Top module: `branch_trace_buf`

## Requirements
- R1: After reset the control register and the status register both read 0, a data read returns 0, `ovf_exc` is low, and the readout machine is in `PH_DST`.
- R2: The control register is at offset 0x000 and can be read and written. Its bits are: bit 0 power, bit 1 enable, bit 2 overflow-exception mode, bit 3 single-level compression, bit 4 two-level compression. Bits 31..5 read as 0.
- R3: The status register is at offset 0x004 and reads the number of held pairs, saturated at 16. Writes to the status register and to the data register (offset 0x100) change no state.
- R4: An event with `br_valid` high is recorded only if the power bit and the enable bit are both set.
- R5: An event with `br_hwloop` set is never recorded. No event is recorded while `br_level` equals 1 (reset level).
- R6: When overflow-exception mode is set, events at levels 0 to 3 are dropped and raise no exception.
- R7: If the store is full and overflow-exception mode is set, a qualifying event is dropped and `ovf_exc` is high for the one cycle after that event. No pair changes, including pairs the event could have folded into.
- R8: If the store is full and overflow-exception mode is clear, an event that is not folded discards the oldest pair and is stored as the newest.
- R9: Single-level compression applies when it is enabled and at least one pair is held. An event whose source and destination equal those of the newest pair, with bit 0 ignored on both sides, is not stored. Instead, bit 0 of the newest pair's destination is set.
- R10: Two-level compression applies when it is enabled, at least two pairs are held, and single-level compression did not already fold the event. An event that matches the second-newest pair (bit 0 ignored) is not stored. Instead, bit 0 of that pair's source is set.
- R11: A data read of an empty store returns 0. Otherwise the first data read returns the newest destination, and the next returns its source and removes that pair, so pairs come out newest first.
- R12: Every request is answered in the next cycle by a one-cycle `bus_ack`, with read data in the same cycle. A request counts as word-sized only if `bus_size` is 2'b10. A request that is not word-sized, or that targets an offset other than 0x000, 0x004 or 0x100, returns 0 with `bus_err` high and has no effect.
- R13: If a removing data read and a recorded event happen in the same cycle, the removal is applied first. Compression and the full check then see the store after the removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch event strobe |
| br_src | input | 32 | Source program counter of the branch |
| br_dst | input | 32 | Destination program counter of the branch |
| br_hwloop | input | 1 | Branch is the back edge of a hardware loop |
| br_level | input | 4 | Current interrupt priority level (0 highest) |
| bus_req | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_size | input | 2 | Access size, 2'b10 = 32-bit |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response valid, one cycle after the request |
| bus_err | output | 1 | Response is an error |
| bus_rdata | output | 32 | Read data |
| ovf_exc | output | 1 | Overflow-exception request pulse |

## Verification
The assertions assume that `bus_req`, `br_valid` and the bus fields are driven only with settled values and are held low during reset. They also assume that `br_level` never goes above 15. The stimulus changes inputs only on the falling clock edge and releases them after each cycle. Random levels, sizes and offsets are drawn from legal encodings plus a small share of malformed accesses. Program counters are drawn from a small pool, so the compression checks, the full check and the same-cycle pop-and-record case happen often while staying inside those assumptions.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int WORD_W   = 32;
    localparam int CTRL_W   = 5;
    localparam int LVL_W    = 4;
    localparam int STAT_CAP = 16;

    // control register bit positions
    localparam int B_PWR = 0;
    localparam int B_EN  = 1;
    localparam int B_OVX = 2;
    localparam int B_C1  = 3;
    localparam int B_C2  = 4;

    localparam logic [LVL_W-1:0] LVL_RESET   = 4'd1;
    localparam logic [LVL_W-1:0] LVL_EXC_MAX = 4'd3;
    localparam logic [1:0]       SZ_WORD     = 2'b10;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
    } pair_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_PUSH,
        ACT_FOLD1,
        ACT_FOLD2
    } act_t;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_OK,
        RSP_ERR
    } rsp_t;

    typedef enum logic {
        PH_DST,
        PH_SRC
    } phase_t;

    function automatic logic pc_same(input logic [WORD_W-1:0] a,
                                     input logic [WORD_W-1:0] b);
        return a[WORD_W-1:1] == b[WORD_W-1:1];
    endfunction

endpackage

// File: rtl/btb_ring.sv
module btb_ring
    import btb_pkg::*;
#(
    parameter int PW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  act_t              act,
    input  logic [WORD_W-1:0] ev_src,
    input  logic [WORD_W-1:0] ev_dst,
    output logic [PW:0]       len_raw,
    output pair_t             newest_raw,
    output logic [PW:0]       len_view,
    output pair_t             view1,
    output pair_t             view2
);

    localparam int DEPTH = 1 << PW;
    localparam logic [PW:0] ONE  = (PW+1)'(1);
    localparam logic [PW:0] TWO  = (PW+1)'(2);
    localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

    logic [PW:0] top_q, bot_q;
    pair_t       store [DEPTH];

    logic [PW:0] top_v, p_raw, p1, p2;
    logic        full_v, do_push;

    assign len_raw    = top_q - bot_q;
    assign p_raw      = top_q - ONE;
    assign newest_raw = store[p_raw[PW-1:0]];

    // pointers seen by the event path once this cycle's pop is applied
    assign top_v    = pop ? (top_q - ONE) : top_q;
    assign len_view = top_v - bot_q;
    assign p1       = top_v - ONE;
    assign p2       = top_v - TWO;
    assign view1    = store[p1[PW-1:0]];
    assign view2    = store[p2[PW-1:0]];
    assign full_v   = (len_view == FULL);
    assign do_push  = (act == ACT_PUSH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
            bot_q <= '0;
        end else begin
            top_q <= do_push ? (top_v + ONE) : top_v;
            if (do_push && full_v)
                bot_q <= bot_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_PUSH:  store[top_v[PW-1:0]] <= '{src: ev_src, dst: ev_dst};
            ACT_FOLD1: store[p1[PW-1:0]].dst[0] <= 1'b1;
            ACT_FOLD2: store[p2[PW-1:0]].src[0] <= 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/btb_qualify.sv
module btb_qualify
    import btb_pkg::*;
#(
    parameter int PW = 6
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              ev_valid,
    input  logic [WORD_W-1:0] ev_src,
    input  logic [WORD_W-1:0] ev_dst,
    input  logic              ev_hwloop,
    input  logic [LVL_W-1:0]  ev_level,
    input  logic [PW:0]       len_view,
    input  pair_t             view1,
    input  pair_t             view2,
    output act_t              act,
    output logic              ovf_hit
);

    localparam logic [PW:0] FULL = (PW+1)'(DEPTH_V);
    localparam int DEPTH_V = 1 << PW;

    logic rec_ok, full, hit1, hit2, high_lvl;

    assign high_lvl = (ev_level <= LVL_EXC_MAX);
    assign rec_ok   = ev_valid && ctrl[B_PWR] && ctrl[B_EN] && !ev_hwloop
                      && (ev_level != LVL_RESET)
                      && !(ctrl[B_OVX] && high_lvl);
    assign full     = (len_view == FULL);
    assign hit1     = ctrl[B_C1] && (len_view != '0)
                      && pc_same(ev_src, view1.src) && pc_same(ev_dst, view1.dst);
    assign hit2     = ctrl[B_C2] && (len_view >= (PW+1)'(2))
                      && pc_same(ev_src, view2.src) && pc_same(ev_dst, view2.dst);

    always_comb begin
        act     = ACT_NONE;
        ovf_hit = 1'b0;
        if (rec_ok) begin
            if (full && ctrl[B_OVX])
                ovf_hit = 1'b1;
            else if (hit1)
                act = ACT_FOLD1;
            else if (hit2)
                act = ACT_FOLD2;
            else
                act = ACT_PUSH;
        end
    end

endmodule

// File: rtl/btb_regif.sv
module btb_regif
    import btb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [PW:0]       len_raw,
    input  pair_t             newest_raw,
    output logic [CTRL_W-1:0] ctrl,
    output logic              pop,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [WORD_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(12'h000);
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(12'h004);
    localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(12'h100);

    rsp_t              rsp_q, rsp_n;
    phase_t            ph_q, ph_n;
    logic [CTRL_W-1:0] ctrl_q;
    logic [WORD_W-1:0] rdata_q, rd_val, len32, stat_v;
    logic              sel_c, sel_s, sel_d, acc_ok, rd_dat, nonempty;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[WORD_W-1:CTRL_W];

    assign sel_c    = (bus_addr == OFF_CTRL);
    assign sel_s    = (bus_addr == OFF_STAT);
    assign sel_d    = (bus_addr == OFF_DATA);
    assign acc_ok   = bus_req && (bus_size == SZ_WORD) && (sel_c || sel_s || sel_d);
    assign rd_dat   = acc_ok && !bus_wr && sel_d;
    assign nonempty = (len_raw != '0);
    assign pop      = rd_dat && nonempty && (ph_q == PH_SRC);
    assign ctrl     = ctrl_q;

    assign len32  = WORD_W'(len_raw);
    assign stat_v = (len32 > WORD_W'(STAT_CAP)) ? WORD_W'(STAT_CAP) : len32;

    // next-state logic of both machines
    always_comb begin
        if (!bus_req)
            rsp_n = RSP_IDLE;
        else if (acc_ok)
            rsp_n = RSP_OK;
        else
            rsp_n = RSP_ERR;

        ph_n = ph_q;
        if (rd_dat && nonempty) begin
            unique case (ph_q)
                PH_DST: ph_n = PH_SRC;
                PH_SRC: ph_n = PH_DST;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        if (sel_c)
            rd_val = WORD_W'(ctrl_q);
        else if (sel_s)
            rd_val = stat_v;
        else if (sel_d && nonempty)
            rd_val = (ph_q == PH_DST) ? newest_raw.dst : newest_raw.src;
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q   <= RSP_IDLE;
            ph_q    <= PH_DST;
            ctrl_q  <= '0;
            rdata_q <= '0;
        end else begin
            rsp_q   <= rsp_n;
            ph_q    <= ph_n;
            rdata_q <= (acc_ok && !bus_wr) ? rd_val : '0;
            if (acc_ok && bus_wr && sel_c)
                ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    // outputs from response state
    always_comb begin
        bus_ack   = 1'b0;
        bus_err   = 1'b0;
        bus_rdata = '0;
        unique case (rsp_q)
            RSP_IDLE: ;
            RSP_OK: begin
                bus_ack   = 1'b1;
                bus_rdata = rdata_q;
            end
            RSP_ERR: begin
                bus_ack = 1'b1;
                bus_err = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/branch_trace_buf.sv
module branch_trace_buf
    import btb_pkg::*;
#(
    parameter int DEPTH_LOG2 = 6,
    parameter int ADDR_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [31:0]       br_src,
    input  logic [31:0]       br_dst,
    input  logic              br_hwloop,
    input  logic [3:0]        br_level,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [31:0]       bus_rdata,
    output logic              ovf_exc
);

    logic [CTRL_W-1:0]   ctrl_q;
    logic                pop;
    act_t                act;
    logic                ovf_hit;
    logic [DEPTH_LOG2:0] ring_len, len_view;
    pair_t               newest_raw, view1, view2;

    btb_regif #(.ADDR_W(ADDR_W), .PW(DEPTH_LOG2)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .len_raw    (ring_len),
        .newest_raw (newest_raw),
        .ctrl       (ctrl_q),
        .pop        (pop),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata)
    );

    btb_qualify #(.PW(DEPTH_LOG2)) u_qual (
        .ctrl      (ctrl_q),
        .ev_valid  (br_valid),
        .ev_src    (br_src),
        .ev_dst    (br_dst),
        .ev_hwloop (br_hwloop),
        .ev_level  (br_level),
        .len_view  (len_view),
        .view1     (view1),
        .view2     (view2),
        .act       (act),
        .ovf_hit   (ovf_hit)
    );

    btb_ring #(.PW(DEPTH_LOG2)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (pop),
        .act        (act),
        .ev_src     (br_src),
        .ev_dst     (br_dst),
        .len_raw    (ring_len),
        .newest_raw (newest_raw),
        .len_view   (len_view),
        .view1      (view1),
        .view2      (view2)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_exc <= 1'b0;
        else
            ovf_exc <= ovf_hit;
    end

endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
    parameter int PW = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_ack,
    input logic        bus_err,
    input logic [31:0] bus_rdata,
    input logic        ovf_exc,
    input logic [4:0]  ctrl_q,
    input logic [PW:0] ring_len
);

    localparam int DEPTH = 1 << PW;

    // R12
    ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ack);

    // R12
    err_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_ack && bus_rdata == 32'd0));

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ring_len) <= DEPTH);

    // R7
    ovf_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> (int'($past(ring_len)) == DEPTH));

    // R4
    no_record_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |=> (ring_len <= $past(ring_len)));

endmodule

bind branch_trace_buf btb_chk #(.PW(DEPTH_LOG2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .ovf_exc   (ovf_exc),
    .ctrl_q    (ctrl_q),
    .ring_len  (ring_len)
);

// File: tb/branch_trace_buf_tb.sv
module branch_trace_buf_tb;

    localparam int CLK_P = 10;
    localparam int PW    = 6;
    localparam int DEPTH = 1 << PW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0, br_hwloop = 1'b0;
    logic [31:0] br_src = '0, br_dst = '0;
    logic [3:0]  br_level = '0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err, ovf_exc;
    logic [31:0] bus_rdata;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] s; logic [31:0] d; } ent_t;
    ent_t       mq[$];
    bit         m_src_ph = 1'b0;
    logic [4:0] m_ctrl = '0;

    always #(CLK_P/2) clk = ~clk;

    branch_trace_buf #(.DEPTH_LOG2(PW), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
        .br_hwloop(br_hwloop), .br_level(br_level),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .ovf_exc(ovf_exc)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit pc_eq(input logic [31:0] a, input logic [31:0] b);
        return a[31:1] == b[31:1];
    endfunction

    task automatic step(input bit req, input bit wr, input logic [11:0] a,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input bit ev, input logic [31:0] s, input logic [31:0] d,
                        input bit hw, input logic [3:0] lv, input string tag);
        logic [4:0]  c;
        bit          e_err, e_exc;
        logic [31:0] e_rd;
        int          n;
        c     = m_ctrl;
        e_err = req && (sz != 2'b10 || !(a == 12'h000 || a == 12'h004 || a == 12'h100));
        e_rd  = '0;
        e_exc = 1'b0;
        if (req && !e_err) begin
            if (wr) begin
                if (a == 12'h000) m_ctrl = wd[4:0];
            end else if (a == 12'h000) begin
                e_rd = {27'd0, m_ctrl};
            end else if (a == 12'h004) begin
                e_rd = (mq.size() > 16) ? 32'd16 : 32'(mq.size());
            end else if (mq.size() != 0) begin
                if (!m_src_ph) begin
                    e_rd = mq[$].d;
                    m_src_ph = 1'b1;
                end else begin
                    e_rd = mq[$].s;
                    void'(mq.pop_back());
                    m_src_ph = 1'b0;
                end
            end
        end
        if (ev && c[0] && c[1] && !hw && lv != 4'd1 && !(c[2] && lv <= 4'd3)) begin
            n = mq.size();
            if (n == DEPTH && c[2])
                e_exc = 1'b1;
            else if (c[3] && n >= 1 && pc_eq(s, mq[n-1].s) && pc_eq(d, mq[n-1].d))
                mq[n-1].d[0] = 1'b1;
            else if (c[4] && n >= 2 && pc_eq(s, mq[n-2].s) && pc_eq(d, mq[n-2].d))
                mq[n-2].s[0] = 1'b1;
            else begin
                if (n == DEPTH) void'(mq.pop_front());
                mq.push_back('{s: s, d: d});
            end
        end
        @(negedge clk);
        bus_req = req; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        br_valid = ev; br_src = s; br_dst = d; br_hwloop = hw; br_level = lv;
        @(posedge clk);
        #(CLK_P/4);
        if (req)
            check(bus_ack && bus_err == e_err && bus_rdata == e_rd, tag, "response",
                  {30'd0, bus_ack, bus_err, bus_rdata}, {30'd0, 1'b1, e_err, e_rd});
        else
            check(!bus_ack && !bus_err, tag, "idle response",
                  {62'd0, bus_ack, bus_err}, 64'd0);
        check(ovf_exc == e_exc, tag, "ovf_exc", {63'd0, ovf_exc}, {63'd0, e_exc});
        bus_req = 1'b0; br_valid = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(1, 0, a, 2'b10, 0, 0, 0, 0, 0, 4'd5, tag);
    endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] v, input string tag);
        step(1, 1, a, 2'b10, v, 0, 0, 0, 0, 4'd5, tag);
    endtask
    task automatic ev(input logic [31:0] s, input logic [31:0] d, input bit hw,
                      input logic [3:0] lv, input string tag);
        step(0, 0, 0, 2'b10, 0, 1, s, d, hw, lv, tag);
    endtask
    task automatic drain(input string tag);
        while (mq.size() != 0) rd(12'h100, tag);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5eed_0b7b));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #(CLK_P/4);
        // R1: outputs quiet after reset
        check(!bus_ack && !bus_err && !ovf_exc && bus_rdata == 0, "R1", "reset outputs",
              {29'd0, bus_ack, bus_err, ovf_exc, bus_rdata}, 64'd0);
        rd(12'h000, "R1"); rd(12'h004, "R1"); rd(12'h100, "R1");

        // R2: control read back, upper bits zero
        wr(12'h000, 32'hFFFF_FFFF, "R2"); rd(12'h000, "R2");
        wr(12'h000, 32'h0000_000A, "R2"); rd(12'h000, "R2");

        // R4: power or enable alone records nothing
        wr(12'h000, 32'h1, "R4"); ev(32'h100, 32'h200, 0, 4'd6, "R4"); rd(12'h004, "R4");
        wr(12'h000, 32'h2, "R4"); ev(32'h100, 32'h200, 0, 4'd6, "R4"); rd(12'h004, "R4");
        wr(12'h000, 32'h3, "R4"); ev(32'h100, 32'h200, 0, 4'd6, "R4"); rd(12'h004, "R4");

        // R5: hardware loop and reset level ignored
        ev(32'h300, 32'h400, 1, 4'd6, "R5"); ev(32'h500, 32'h600, 0, 4'd1, "R5");
        rd(12'h004, "R5");

        // R11: newest first, destination then source; empty keeps phase
        ev(32'h700, 32'h800, 0, 4'd2, "R11");
        rd(12'h100, "R11"); rd(12'h100, "R11"); rd(12'h100, "R11");
        rd(12'h100, "R11"); rd(12'h100, "R11"); rd(12'h100, "R11");
        ev(32'h900, 32'hA00, 0, 4'd8, "R11"); rd(12'h100, "R11"); rd(12'h100, "R11");

        // R6: overflow mode drops high-priority levels silently
        wr(12'h000, 32'h7, "R6");
        ev(32'h1000, 32'h2000, 0, 4'd3, "R6"); ev(32'h1000, 32'h2000, 0, 4'd0, "R6");
        rd(12'h004, "R6");

        // R7 / R3: fill, then overflow request and saturated count
        for (int i = 0; i < DEPTH; i++) ev(32'h4000 + i*8, 32'h8000 + i*8, 0, 4'd5, "R7");
        rd(12'h004, "R3");
        ev(32'hC000, 32'hD000, 0, 4'd5, "R7"); rd(12'h004, "R7");
        wr(12'h004, 32'h0, "R3"); wr(12'h100, 32'h0, "R3");
        rd(12'h100, "R3");

        // R8: overwrite oldest when full and overflow mode clear
        wr(12'h000, 32'h3, "R8");
        ev(32'hE000, 32'hF000, 0, 4'd5, "R8"); ev(32'hE100, 32'hF100, 0, 4'd5, "R8");
        drain("R8");

        // R9 / R10: compression
        wr(12'h000, 32'h1B, "R9");
        ev(32'h10, 32'h20, 0, 4'd7, "R9"); ev(32'h10, 32'h20, 0, 4'd7, "R9");
        ev(32'h30, 32'h40, 0, 4'd7, "R10"); ev(32'h10, 32'h21, 0, 4'd7, "R10");
        ev(32'h30, 32'h40, 0, 4'd7, "R10");
        rd(12'h004, "R10"); drain("R10");

        // R13: pop and record in one cycle, compression sees post-pop store
        ev(32'h50, 32'h60, 0, 4'd7, "R13"); ev(32'h70, 32'h80, 0, 4'd7, "R13");
        rd(12'h100, "R13");
        step(1, 0, 12'h100, 2'b10, 0, 1, 32'h50, 32'h60, 0, 4'd7, "R13");
        rd(12'h004, "R13"); drain("R13");

        // R12: malformed and unmapped accesses
        ev(32'h90, 32'hA0, 0, 4'd7, "R12");
        step(1, 0, 12'h100, 2'b01, 0, 0, 0, 0, 0, 4'd5, "R12");
        step(1, 1, 12'h000, 2'b00, 32'h0, 0, 0, 0, 0, 4'd5, "R12");
        rd(12'h008, "R12"); rd(12'h101, "R12"); rd(12'h000, "R12");
        drain("R12");

        // random mix
        for (int k = 0; k < 4000; k++) begin
            int r = int'($urandom_range(99));
            bit rq = (r < 45);
            bit w = 1'b0;
            logic [11:0] a = 12'h100;
            logic [1:0]  sz = 2'b10;
            logic [31:0] wd = '0;
            if (r < 6) begin w = 1'b1; a = 12'h000; wd = {$urandom} | 32'h3; end
            else if (r < 10) a = 12'h004;
            else if (r < 12) begin a = 12'(($urandom_range(3)) * 4 + 12'h0F8); sz = 2'($urandom); end
            step(rq, w, a, sz, wd, ($urandom_range(99) < 70),
                 32'h200 + 32'($urandom_range(3)) * 4 + 32'($urandom_range(1)),
                 32'h600 + 32'($urandom_range(3)) * 4,
                 ($urandom_range(9) == 0), 4'($urandom_range(15)), "R13");
        end
        finish_up();
    end

endmodule